// File: doc/BRIEF.md
# Windowed Command and Status Interface

This block is the host-facing control front end of a network controller. The host writes a 16-bit command word to a single port. The block splits that word into a 5-bit opcode and an 11-bit argument. The commands select a register window, enable or disable the receive and transmit paths, request or acknowledge interrupts, program the two interrupt masks and load the three FIFO threshold registers. When the host reads the same port, it gets a 16-bit status word. That word carries the selected window, a command-busy flag, the interrupt latch and the seven interrupt-cause bits.

The RX and TX datapaths pulse event inputs that set sticky cause bits. A single interrupt output is raised while the latch is set and at least one cause bit is both set and enabled in the interrupt mask. A global-reset command returns every register to its power-up state. It then keeps the busy flag high for a parameterised hold time, which by default is 1 ms at 100 MHz. Commands written while the busy flag is high are dropped, so the host must poll the busy flag before it writes again.

Top module: `cmdstat_top`

## Requirements
- R1: A command word carries the opcode in bits 15..11 and the argument in bits 10..0. Opcode 0x01 selects window arg[2:0], and the other argument bits are ignored. Status bits 15..13 always show the selected window.
- R2: Status word layout:
  - bit 0: interrupt latch.
  - bits 7..1, visible only where the read mask allows (R8): adapter failure (1), TX complete (2), TX available (3), RX complete (4), RX early (5), interrupt requested (6), update statistics (7).
  - bit 12: busy.
  - bits 11..8: read as zero.
- R3: An accepted command raises busy (status bit 12) in the next cycle.
  - It holds busy for exactly one cycle for any opcode other than 0x00.
  - It holds busy for exactly HOLD_CYC cycles after opcode 0x00.
  - A command written while busy is high is ignored.
- R4: An event input pulse sets its cause bit (fail→1, tx_done→2, tx_room→3, rx_done→4, rx_early→5, stats→7) and sets the latch. Cause bits stay set until they are acknowledged.
- R5: Opcode 0x0c sets the interrupt-requested cause (bit 6) and the latch.
- R6: Opcode 0x0d clears each cause bit k (1..7) whose argument bit k is 1, and it clears the latch when argument bit 0 is 1. An event in the same cycle wins over the acknowledge.
- R7: Opcode 0x0e loads the interrupt mask from arg[7:1], aligned with status bits 7..1. The irq output is 1 exactly when the latch is set and some cause bit is set together with its mask bit.
- R8: Opcode 0x0f loads the read mask from arg[7:1]. Status bits 7..1 show cause AND read mask. Bit 0 is not masked.
- R9: Opcodes 0x11, 0x12 and 0x13 load the RX-early, TX-available and TX-start thresholds from the 11-bit argument. Each threshold's disable flag is 1 exactly when its value is 2047. All three thresholds are 2047 after reset.
- R10: Opcodes 0x03 and 0x04 disable and enable RX. Opcodes 0x09 and 0x0a enable and disable TX. Both paths are disabled after reset.
- R11: An unrecognised opcode changes no state other than the one-cycle busy flag.
- R12: Power-up reset and opcode 0x00 both do the following:
  - set the window to 0;
  - clear both masks, all cause bits and the latch;
  - disable RX and TX;
  - set all thresholds to 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command word (opcode and argument) |
| status_word | output | 16 | Status read value |
| ev_fail | input | 1 | Adapter failure event pulse |
| ev_tx_done | input | 1 | TX complete event pulse |
| ev_tx_room | input | 1 | TX space available event pulse |
| ev_rx_done | input | 1 | RX complete event pulse |
| ev_rx_early | input | 1 | RX early event pulse |
| ev_stats | input | 1 | Statistics update event pulse |
| irq | output | 1 | Interrupt request |
| rx_enable | output | 1 | Receive path enable |
| tx_enable | output | 1 | Transmit path enable |
| thr_rx_early | output | 11 | RX early threshold |
| thr_tx_avail | output | 11 | TX available threshold |
| thr_tx_start | output | 11 | TX start threshold |
| thr_off | output | 3 | Threshold disabled flags (0 RX early, 1 TX avail, 2 TX start) |

## Verification
The bench targets the corners of this block. It checks the exact length of the busy window after a global reset: a counter that is off by one would release the host one cycle early or late. It writes a command while busy is high; a design that drops the guard would change the window. It fires an event in the same cycle as an acknowledge; a design with the wrong priority would lose the event. It also checks that the latch survives a cause-only acknowledge, and that the threshold value 2047, and no other value, raises the disable flag. Random command and event streams are compared against a reference model held in the bench.

// File: rtl/cmdstat_pkg.sv
// Package: shared widths and opcode values for the command/status front end.
// Assumes a 16-bit host word split into opcode and argument fields.
package cmdstat_pkg;
    localparam int WORD_W  = 16;
    localparam int OP_W    = 5;
    localparam int ARG_W   = 11;
    localparam int WIN_W   = 3;
    localparam int CAUSE_W = 7;
    localparam int N_THR   = 3;
    localparam int PAD_W   = WORD_W - WIN_W - 1 - CAUSE_W - 1;

    localparam logic [OP_W-1:0] OP_GRESET   = 5'h00;
    localparam logic [OP_W-1:0] OP_WINSEL   = 5'h01;
    localparam logic [OP_W-1:0] OP_RX_OFF   = 5'h03;
    localparam logic [OP_W-1:0] OP_RX_ON    = 5'h04;
    localparam logic [OP_W-1:0] OP_TX_ON    = 5'h09;
    localparam logic [OP_W-1:0] OP_TX_OFF   = 5'h0a;
    localparam logic [OP_W-1:0] OP_IRQ_REQ  = 5'h0c;
    localparam logic [OP_W-1:0] OP_IRQ_ACK  = 5'h0d;
    localparam logic [OP_W-1:0] OP_IMASK    = 5'h0e;
    localparam logic [OP_W-1:0] OP_RDMASK   = 5'h0f;
    localparam logic [OP_W-1:0] OP_THR_BASE = 5'h11;

    // Index of the interrupt-requested cause inside the cause vector
    localparam int CZ_REQ = 5;
endpackage

// File: rtl/cmdstat_decode.sv
// Module: cmdstat_decode
// Splits a command word into opcode and argument and raises one strobe per
// recognised command. Assumes 'valid' is already qualified by the busy flag.
module cmdstat_decode
    import cmdstat_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output logic [ARG_W-1:0]  arg,
    output logic              do_greset,
    output logic              do_winsel,
    output logic              do_rx_off,
    output logic              do_rx_on,
    output logic              do_tx_on,
    output logic              do_tx_off,
    output logic              do_irq_req,
    output logic              do_irq_ack,
    output logic              do_imask,
    output logic              do_rdmask,
    output logic [N_THR-1:0]  do_thr,
    output logic              do_unknown
);
    logic [OP_W-1:0] op;

    assign op  = word[WORD_W-1 -: OP_W];
    assign arg = word[ARG_W-1:0];

    // One threshold-load strobe per consecutive opcode from the base
    for (genvar i = 0; i < N_THR; i++) begin : g_thr
        assign do_thr[i] = valid && (op == OP_THR_BASE + OP_W'(i));
    end

    // Fixed-opcode strobes
    always_comb begin
        do_greset  = valid && (op == OP_GRESET);
        do_winsel  = valid && (op == OP_WINSEL);
        do_rx_off  = valid && (op == OP_RX_OFF);
        do_rx_on   = valid && (op == OP_RX_ON);
        do_tx_on   = valid && (op == OP_TX_ON);
        do_tx_off  = valid && (op == OP_TX_OFF);
        do_irq_req = valid && (op == OP_IRQ_REQ);
        do_irq_ack = valid && (op == OP_IRQ_ACK);
        do_imask   = valid && (op == OP_IMASK);
        do_rdmask  = valid && (op == OP_RDMASK);
    end

    // Anything accepted but not matched is flagged as unknown
    always_comb begin
        do_unknown = valid && !(do_greset || do_winsel || do_rx_off || do_rx_on ||
                                do_tx_on || do_tx_off || do_irq_req || do_irq_ack ||
                                do_imask || do_rdmask || (|do_thr));
    end
endmodule

// File: rtl/cmdstat_busy.sv
// Module: cmdstat_busy
// Command-in-progress timer. An accepted command loads a down-counter with
// 1, or with HOLD_CYC for a global reset; busy is high while it is non-zero.
module cmdstat_busy #(
    parameter int HOLD_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic is_greset,
    output logic busy
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Load on accept, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (accept)
            cnt_q <= is_greset ? LOAD_LONG : LOAD_SHORT;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy = (cnt_q != '0);

    a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    a_r3_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !busy);
endmodule

// File: rtl/cmdstat_irq.sv
// Module: cmdstat_irq
// Holds the sticky cause bits, the interrupt latch, the interrupt mask and the
// read mask. Events win over an acknowledge in the same cycle.
module cmdstat_irq
    import cmdstat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_greset,
    input  logic               do_irq_req,
    input  logic               do_irq_ack,
    input  logic               do_imask,
    input  logic               do_rdmask,
    input  logic [CAUSE_W:0]   arg_lo,
    input  logic [CAUSE_W-1:0] ev,
    output logic [CAUSE_W-1:0] cause_view,
    output logic               latch,
    output logic               irq
);
    logic [CAUSE_W-1:0] cause_q, imask_q, rdmask_q, set_v, clr_v;
    logic               latch_q;

    // Bits to set from events or a request, bits to clear from an ack
    always_comb begin
        set_v = ev;
        if (do_irq_req)
            set_v[CZ_REQ] = 1'b1;
        clr_v = do_irq_ack ? arg_lo[CAUSE_W:1] : '0;
    end

    // Cause, latch and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n || do_greset) begin
            cause_q  <= '0;
            latch_q  <= 1'b0;
            imask_q  <= '0;
            rdmask_q <= '0;
        end else begin
            cause_q <= (cause_q & ~clr_v) | set_v;
            if (|set_v)
                latch_q <= 1'b1;
            else if (do_irq_ack && arg_lo[0])
                latch_q <= 1'b0;
            if (do_imask)
                imask_q <= arg_lo[CAUSE_W:1];
            if (do_rdmask)
                rdmask_q <= arg_lo[CAUSE_W:1];
        end
    end

    assign cause_view = cause_q & rdmask_q;
    assign latch      = latch_q;
    assign irq        = latch_q && |(cause_q & imask_q);

    a_r4_event_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev && !do_greset) |=> latch);
    a_r6_ack_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (do_irq_ack && arg_lo[0] && !(|ev)) |=> !latch);
    a_r7_mask_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        do_imask |=> (imask_q == $past(arg_lo[CAUSE_W:1])));
    a_r7_irq_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        do_greset |=> !irq);
endmodule

// File: rtl/cmdstat_cfg.sv
// Module: cmdstat_cfg
// Window selection, RX/TX enables and the threshold registers. A threshold of
// all ones in the argument width means the threshold interrupt is off.
module cmdstat_cfg
    import cmdstat_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        do_greset,
    input  logic                        do_winsel,
    input  logic                        do_rx_off,
    input  logic                        do_rx_on,
    input  logic                        do_tx_on,
    input  logic                        do_tx_off,
    input  logic [N_THR-1:0]            do_thr,
    input  logic [ARG_W-1:0]            arg,
    output logic [WIN_W-1:0]            win,
    output logic                        rx_en,
    output logic                        tx_en,
    output logic [N_THR-1:0][ARG_W-1:0] thr,
    output logic [N_THR-1:0]            thr_off
);
    localparam logic [ARG_W-1:0] THR_DISABLED = '1;

    // Window and path enables
    always_ff @(posedge clk) begin
        if (!rst_n || do_greset) begin
            win   <= '0;
            rx_en <= 1'b0;
            tx_en <= 1'b0;
        end else begin
            if (do_winsel)
                win <= arg[WIN_W-1:0];
            if (do_rx_on)
                rx_en <= 1'b1;
            else if (do_rx_off)
                rx_en <= 1'b0;
            if (do_tx_on)
                tx_en <= 1'b1;
            else if (do_tx_off)
                tx_en <= 1'b0;
        end
    end

    for (genvar i = 0; i < N_THR; i++) begin : g_thr
        // Threshold register i loads on its own opcode
        always_ff @(posedge clk) begin
            if (!rst_n || do_greset)
                thr[i] <= THR_DISABLED;
            else if (do_thr[i])
                thr[i] <= arg;
        end
        assign thr_off[i] = (thr[i] == THR_DISABLED);

        a_r9_thr_loaded: assert property (@(posedge clk) disable iff (!rst_n)
            (do_thr[i] && !do_greset) |=> (thr[i] == $past(arg)));
    end

    a_r1_window_follows: assert property (@(posedge clk) disable iff (!rst_n)
        do_winsel |=> (win == $past(arg[WIN_W-1:0])));
    a_r12_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        do_greset |=> (win == '0 && !rx_en && !tx_en));
    a_r10_rx_on: assert property (@(posedge clk) disable iff (!rst_n)
        do_rx_on |=> rx_en);
endmodule

// File: rtl/cmdstat_top.sv
// Module: cmdstat_top
// Host command/status port. Accepts a command when the busy flag is low,
// decodes it, and assembles the status word from window, busy, causes, latch.
module cmdstat_top
    import cmdstat_pkg::*;
#(
    parameter int HOLD_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_word,
    output logic [WORD_W-1:0] status_word,
    input  logic              ev_fail,
    input  logic              ev_tx_done,
    input  logic              ev_tx_room,
    input  logic              ev_rx_done,
    input  logic              ev_rx_early,
    input  logic              ev_stats,
    output logic              irq,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic [ARG_W-1:0]  thr_rx_early,
    output logic [ARG_W-1:0]  thr_tx_avail,
    output logic [ARG_W-1:0]  thr_tx_start,
    output logic [N_THR-1:0]  thr_off
);
    logic                        busy, accept;
    logic [ARG_W-1:0]            arg;
    logic                        do_greset, do_winsel, do_rx_off, do_rx_on;
    logic                        do_tx_on, do_tx_off, do_irq_req, do_irq_ack;
    logic                        do_imask, do_rdmask, do_unknown;
    logic [N_THR-1:0]            do_thr;
    logic [CAUSE_W-1:0]          ev_vec, cause_view;
    logic                        latch;
    logic [WIN_W-1:0]            win;
    logic [N_THR-1:0][ARG_W-1:0] thr;

    assign accept = cmd_wr && !busy;

    // Event pins mapped onto cause indices (status bit = index + 1)
    assign ev_vec = {ev_stats, 1'b0, ev_rx_early, ev_rx_done,
                     ev_tx_room, ev_tx_done, ev_fail};

    cmdstat_decode u_dec (
        .valid(accept), .word(cmd_word), .arg(arg),
        .do_greset(do_greset), .do_winsel(do_winsel),
        .do_rx_off(do_rx_off), .do_rx_on(do_rx_on),
        .do_tx_on(do_tx_on), .do_tx_off(do_tx_off),
        .do_irq_req(do_irq_req), .do_irq_ack(do_irq_ack),
        .do_imask(do_imask), .do_rdmask(do_rdmask),
        .do_thr(do_thr), .do_unknown(do_unknown)
    );

    cmdstat_busy #(.HOLD_CYC(HOLD_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .is_greset(do_greset), .busy(busy)
    );

    cmdstat_irq u_irq (
        .clk(clk), .rst_n(rst_n), .do_greset(do_greset),
        .do_irq_req(do_irq_req), .do_irq_ack(do_irq_ack),
        .do_imask(do_imask), .do_rdmask(do_rdmask),
        .arg_lo(arg[CAUSE_W:0]), .ev(ev_vec),
        .cause_view(cause_view), .latch(latch), .irq(irq)
    );

    cmdstat_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .do_greset(do_greset),
        .do_winsel(do_winsel), .do_rx_off(do_rx_off), .do_rx_on(do_rx_on),
        .do_tx_on(do_tx_on), .do_tx_off(do_tx_off), .do_thr(do_thr),
        .arg(arg), .win(win), .rx_en(rx_enable), .tx_en(tx_enable),
        .thr(thr), .thr_off(thr_off)
    );

    assign thr_rx_early = thr[0];
    assign thr_tx_avail = thr[1];
    assign thr_tx_start = thr[2];

    // Status word assembly
    assign status_word = {win, busy, {PAD_W{1'b0}}, cause_view, latch};

    a_r11_unknown_keeps_window: assert property (@(posedge clk) disable iff (!rst_n)
        do_unknown |=> $stable(win));
    a_r11_unknown_keeps_enables: assert property (@(posedge clk) disable iff (!rst_n)
        do_unknown |=> ($stable(rx_enable) && $stable(tx_enable)));
endmodule

// File: tb/cmdstat_top_tb.sv
module cmdstat_top_tb;
    localparam int HOLD = 500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [15:0] status_word;
    logic        ev_fail = 0, ev_tx_done = 0, ev_tx_room = 0;
    logic        ev_rx_done = 0, ev_rx_early = 0, ev_stats = 0;
    logic        irq, rx_enable, tx_enable;
    logic [10:0] thr_rx_early, thr_tx_avail, thr_tx_start;
    logic [2:0]  thr_off;

    int n_run = 0, n_fail = 0;

    // reference model state
    logic [2:0]  m_win;
    logic [6:0]  m_cause, m_imask, m_rdmask;
    logic        m_latch, m_rx, m_tx;
    logic [10:0] m_thr [3];

    always #5 clk = ~clk;

    cmdstat_top #(.HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .status_word(status_word), .ev_fail(ev_fail), .ev_tx_done(ev_tx_done),
        .ev_tx_room(ev_tx_room), .ev_rx_done(ev_rx_done),
        .ev_rx_early(ev_rx_early), .ev_stats(ev_stats), .irq(irq),
        .rx_enable(rx_enable), .tx_enable(tx_enable),
        .thr_rx_early(thr_rx_early), .thr_tx_avail(thr_tx_avail),
        .thr_tx_start(thr_tx_start), .thr_off(thr_off)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_win = '0; m_cause = '0; m_imask = '0; m_rdmask = '0;
        m_latch = 1'b0; m_rx = 1'b0; m_tx = 1'b0;
        for (int i = 0; i < 3; i++) m_thr[i] = 11'h7ff;
    endtask

    function automatic logic [15:0] exp_status(input logic busy);
        return {m_win, busy, 4'b0, m_cause & m_rdmask, m_latch};
    endfunction

    function automatic logic exp_irq();
        return m_latch && |(m_cause & m_imask);
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " R1/R2/R8 status"}, 32'(status_word), 32'(exp_status(1'b0)));
        chk({tag, " R7 irq"}, 32'(irq), 32'(exp_irq()));
        chk({tag, " R10 enables"}, {30'b0, rx_enable, tx_enable}, {30'b0, m_rx, m_tx});
        chk({tag, " R9 thresholds"}, {thr_tx_start, thr_tx_avail, thr_rx_early},
            {m_thr[2], m_thr[1], m_thr[0]});
        chk({tag, " R9 disable flags"}, 32'(thr_off),
            {29'b0, m_thr[2] == 11'h7ff, m_thr[1] == 11'h7ff, m_thr[0] == 11'h7ff});
    endtask

    task automatic model_cmd(input logic [4:0] op, input logic [10:0] arg);
        case (op)
            5'h00: model_reset();
            5'h01: m_win = arg[2:0];
            5'h03: m_rx = 1'b0;
            5'h04: m_rx = 1'b1;
            5'h09: m_tx = 1'b1;
            5'h0a: m_tx = 1'b0;
            5'h0c: begin m_cause[5] = 1'b1; m_latch = 1'b1; end
            5'h0d: begin
                m_cause = m_cause & ~arg[7:1];
                if (arg[0]) m_latch = 1'b0;
            end
            5'h0e: m_imask = arg[7:1];
            5'h0f: m_rdmask = arg[7:1];
            5'h11: m_thr[0] = arg;
            5'h12: m_thr[1] = arg;
            5'h13: m_thr[2] = arg;
            default: ;
        endcase
    endtask

    task automatic drive_ev(input logic [6:0] v);
        ev_fail = v[0]; ev_tx_done = v[1]; ev_tx_room = v[2];
        ev_rx_done = v[3]; ev_rx_early = v[4]; ev_stats = v[6];
    endtask

    // Issue one command; check the busy window (R3), then all outputs
    task automatic send_cmd(input logic [4:0] op, input logic [10:0] arg, input string tag);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = {op, arg};
        @(negedge clk);
        cmd_wr = 1'b0;
        model_cmd(op, arg);
        chk({tag, " R3 busy set"}, 32'(status_word[12]), 32'd1);
        if (op == 5'h00) begin
            repeat (HOLD - 1) @(negedge clk);
            chk({tag, " R3 busy held to last cycle"}, 32'(status_word[12]), 32'd1);
        end
        @(negedge clk);
        chk({tag, " R3 busy released"}, 32'(status_word[12]), 32'd0);
        check_all(tag);
    endtask

    task automatic pulse_ev(input logic [6:0] v, input string tag);
        @(negedge clk);
        drive_ev(v);
        @(negedge clk);
        drive_ev(7'b0);
        m_cause = m_cause | (v & 7'b1011111);
        if (|(v & 7'b1011111)) m_latch = 1'b1;
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [4:0] ops [14];
        void'($urandom(32'd913));
        ops = '{5'h01, 5'h03, 5'h04, 5'h09, 5'h0a, 5'h0c, 5'h0d,
                5'h0e, 5'h0f, 5'h11, 5'h12, 5'h13, 5'h07, 5'h1f};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("reset R12");
        chk("reset R3 not busy", 32'(status_word[12]), 32'd0);

        send_cmd(5'h0f, 11'h0fe, "rdmask all R8");
        send_cmd(5'h0e, 11'h0fe, "imask all R7");
        send_cmd(5'h01, 11'h7f5, "window 5 upper arg bits R1");

        pulse_ev(7'b0000010, "tx_done event R4");
        chk("R2 tx complete is status bit 2", 32'(status_word[2]), 32'd1);
        send_cmd(5'h0d, 11'h004, "ack cause only R6");
        chk("R6 latch survives cause ack", 32'(status_word[0]), 32'd1);
        send_cmd(5'h0d, 11'h001, "ack latch R6");
        send_cmd(5'h0c, 11'h000, "request intr R5");
        chk("R5 status bit 6", 32'(status_word[6]), 32'd1);
        send_cmd(5'h0e, 11'h000, "imask zero R7");
        chk("R7 irq masked", 32'(irq), 32'd0);
        send_cmd(5'h0f, 11'h000, "rdmask zero R8");
        chk("R8 latch unmasked", 32'(status_word[0]), 32'd1);
        send_cmd(5'h0f, 11'h0fe, "rdmask restore R8");
        send_cmd(5'h0e, 11'h0fe, "imask restore R7");

        send_cmd(5'h11, 11'd100, "rx early thr R9");
        send_cmd(5'h12, 11'd2046, "tx avail 2046 R9");
        send_cmd(5'h13, 11'd0, "tx start 0 R9");
        send_cmd(5'h12, 11'd2047, "tx avail off R9");
        send_cmd(5'h04, 11'h000, "rx on R10");
        send_cmd(5'h09, 11'h000, "tx on R10");
        send_cmd(5'h0a, 11'h000, "tx off R10");
        send_cmd(5'h07, 11'h7ff, "unknown op R11");
        send_cmd(5'h1f, 11'h7ff, "unknown op 1f R11");

        // write while busy is dropped (R3)
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = {5'h01, 11'h002};
        @(negedge clk);
        cmd_word = {5'h01, 11'h006};
        model_cmd(5'h01, 11'h002);
        @(negedge clk);
        cmd_wr = 1'b0;
        @(negedge clk);
        check_all("R3 write during busy ignored");

        // event wins over ack in same cycle (R6)
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = {5'h0d, 11'h0ff};
        drive_ev(7'b0001000);
        @(negedge clk);
        cmd_wr = 1'b0; drive_ev(7'b0);
        m_cause = (m_cause & ~7'h7f) | 7'b0001000;
        m_latch = 1'b1;
        @(negedge clk);
        check_all("R6 event beats ack");

        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 2) == 0) begin
                pulse_ev(7'($urandom()), "random event R4");
            end else begin
                logic [10:0] a;
                a = 11'($urandom());
                if ($urandom_range(0, 3) == 0) a = 11'h7ff;
                send_cmd(ops[$urandom_range(0, 13)], a, "random cmd");
            end
        end

        send_cmd(5'h00, 11'h5a5, "global reset R12");
        chk("R12 window zero", 32'(status_word[15:13]), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule